// File: doc/BRIEF.md
# Four-Phase Register Bus Target Model

This block is a synthesizable stand-in for the register side of a four-phase strobe/acknowledge control bus. A master talks to it through a single 16-bit input bus and four request strobes. One strobe latches the input as the target address and a second latches it as pending write data. A third commits the pending data to the addressed register, and the fourth returns the addressed register on a 16-bit output bus. Each accepted request is answered by an acknowledge that rises after a programmable number of cycles. It stays high until the master drops the strobe it was serving, and then it falls.

The model exists to exercise a bus master: the acknowledge latency can be swept, and one delay setting suppresses the acknowledge altogether so that the master's timeout path can be driven. After reset the register array is filled with a computed pattern (base plus index times step), one entry per cycle. It is held in a plain memory so that block RAM can be inferred.

Top module: `hsk_reg_target`

## Requirements
- R1: After reset `ack` and `dout` are 0, and once the fill has finished (DEPTH cycles after reset release) register i reads back as `RST_BASE + i*RST_STEP` (16-bit wrap).
- R2: A rising `cap_addr` latches `din` as the current address; only the low log2(DEPTH) bits select a register, and higher address bits have no effect.
- R3: A rising `cap_data` latches `din` as pending data and changes no register.
- R4: A rising `wr_stb` copies the pending data into the register at the latched address.
- R5: A rising `rd_stb` puts the addressed register on `dout` on the same clock edge at which `ack` rises; `dout` keeps that value until the next completed read.
- R6: With `ack_dly` = D (not all ones), `ack` goes high on the (D+2)-th rising edge, counting the first edge at which the strobe is sampled high as edge 1. It stays high while the served strobe is high and falls on the first edge at which that strobe is sampled low.
- R7: With `ack_dly` all ones, an accepted strobe is never acknowledged and has no effect on any register or on `dout`.
- R8: A strobe that rises while a request is pending or `ack` is high is ignored, even if it stays high after `ack` falls.
- R9: When several strobes rise at the same edge, only one is served, in the priority `cap_addr` > `cap_data` > `wr_stb` > `rd_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_dly | input | DLY_W | Acknowledge delay in cycles; all ones suppresses acknowledge |
| din | input | DW | Address or data value from the master |
| cap_addr | input | 1 | Capture-address strobe |
| cap_data | input | 1 | Capture-data strobe |
| wr_stb | input | 1 | Commit-write strobe |
| rd_stb | input | 1 | Read strobe |
| ack | output | 1 | Acknowledge |
| dout | output | DW | Read data |

## Verification
The assertions watch, on every cycle, that `ack` drops one edge after all strobes are gone, that `ack` is low for at least two edges before each rise, that `dout` moves only together with a rising `ack`, and that `ack` stays low under a long-held suppress setting. What the bench alone can show is the data path: the reset fill pattern, address aliasing, that captured data is invisible until committed, the exact acknowledge latency for each delay, the dropping of late strobes, and which of several simultaneous strobes wins.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ADDR,
    OP_DATA,
    OP_WRITE,
    OP_READ
  } op_e;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_IDLE,
    ST_WAIT,
    ST_HOLD,
    ST_MUTE
  } st_e;

  localparam int NSTB = 4;

  // strobe lane index to operation; lower lane has higher priority
  function automatic op_e lane_op(input int lane);
    case (lane)
      0: return OP_ADDR;
      1: return OP_DATA;
      2: return OP_WRITE;
      3: return OP_READ;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic [1:0] op_lane(input op_e op);
    case (op)
      OP_ADDR:  return 2'd0;
      OP_DATA:  return 2'd1;
      OP_WRITE: return 2'd2;
      default:  return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/hsk_strobe_sel.sv
module hsk_strobe_sel
  import hsk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSTB-1:0] stb,
  output op_e             req_op
);

  logic [NSTB-1:0] stb_prev;
  logic [NSTB-1:0] stb_rise;

  always_ff @(posedge clk) begin
    if (rst) stb_prev <= '1;
    else     stb_prev <= stb;
  end

  assign stb_rise = stb & ~stb_prev;

  always_comb begin
    req_op = OP_NONE;
    for (int i = NSTB - 1; i >= 0; i--) begin
      if (stb_rise[i]) req_op = lane_op(i);
    end
  end

endmodule

// File: rtl/hsk_sequencer.sv
module hsk_sequencer
  import hsk_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          DEPTH    = 16,
  parameter int          DLY_W    = 4,
  parameter logic [15:0] RST_BASE = 16'hA5C3,
  parameter logic [15:0] RST_STEP = 16'h0111,
  localparam int         AW       = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  op_e             req_op,
  input  logic [NSTB-1:0] stb,
  input  logic [DW-1:0]   din,
  input  logic [DLY_W-1:0] ack_dly,
  output logic            ack,
  output logic            mem_we,
  output logic [AW-1:0]   mem_waddr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_re,
  output logic [AW-1:0]   mem_raddr
);

  localparam logic [DLY_W-1:0] DLY_MUTE = '1;
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

  st_e             st;
  op_e             op_q;
  logic [DW-1:0]   din_q;
  logic [DW-1:0]   addr_q;
  logic [DW-1:0]   pend_q;
  logic [DLY_W-1:0] cnt;
  logic [AW-1:0]   fill_idx;
  logic [DW-1:0]   fill_pat;
  logic            done;
  logic            served_hi;

  assign done      = (st == ST_WAIT) && (cnt == '0);
  assign served_hi = stb[op_lane(op_q)];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_FILL;
      op_q     <= OP_NONE;
      din_q    <= '0;
      addr_q   <= '0;
      pend_q   <= '0;
      cnt      <= '0;
      ack      <= 1'b0;
      fill_idx <= '0;
      fill_pat <= DW'(RST_BASE);
    end else begin
      case (st)
        ST_FILL: begin
          fill_idx <= fill_idx + 1'b1;
          fill_pat <= fill_pat + DW'(RST_STEP);
          if (fill_idx == LAST_IDX) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_op != OP_NONE) begin
            op_q  <= req_op;
            din_q <= din;
            cnt   <= ack_dly;
            st    <= (ack_dly == DLY_MUTE) ? ST_MUTE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            ack <= 1'b1;
            st  <= ST_HOLD;
            if (op_q == OP_ADDR) addr_q <= din_q;
            if (op_q == OP_DATA) pend_q <= din_q;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (!served_hi) begin
            ack <= 1'b0;
            st  <= ST_IDLE;
          end
        end
        ST_MUTE: begin
          if (!served_hi) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (st == ST_FILL) begin
      mem_we    = 1'b1;
      mem_waddr = fill_idx;
      mem_wdata = fill_pat;
    end else begin
      mem_we    = done && (op_q == OP_WRITE);
      mem_waddr = addr_q[AW-1:0];
      mem_wdata = pend_q;
    end
  end

  assign mem_re    = done && (op_q == OP_READ);
  assign mem_raddr = addr_q[AW-1:0];

endmodule

// File: rtl/hsk_regfile.sv
module hsk_regfile #(
  parameter int  DW    = 16,
  parameter int  DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/hsk_reg_target.sv
module hsk_reg_target
  import hsk_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          DEPTH    = 16,
  parameter int          DLY_W    = 4,
  parameter logic [15:0] RST_BASE = 16'hA5C3,
  parameter logic [15:0] RST_STEP = 16'h0111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DLY_W-1:0] ack_dly,
  input  logic [DW-1:0]    din,
  input  logic             cap_addr,
  input  logic             cap_data,
  input  logic             wr_stb,
  input  logic             rd_stb,
  output logic             ack,
  output logic [DW-1:0]    dout
);

  localparam int AW = $clog2(DEPTH);

  logic [NSTB-1:0] stb;
  op_e             req_op;
  logic            mem_we;
  logic [AW-1:0]   mem_waddr;
  logic [DW-1:0]   mem_wdata;
  logic            mem_re;
  logic [AW-1:0]   mem_raddr;

  assign stb = {rd_stb, wr_stb, cap_data, cap_addr};

  hsk_strobe_sel u_sel (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .req_op (req_op)
  );

  hsk_sequencer #(
    .DW       (DW),
    .DEPTH    (DEPTH),
    .DLY_W    (DLY_W),
    .RST_BASE (RST_BASE),
    .RST_STEP (RST_STEP)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_op    (req_op),
    .stb       (stb),
    .din       (din),
    .ack_dly   (ack_dly),
    .ack       (ack),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr)
  );

  hsk_regfile #(
    .DW    (DW),
    .DEPTH (DEPTH)
  ) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (dout)
  );

endmodule

// File: rtl/hsk_reg_target_chk.sv
module hsk_reg_target_chk #(
  parameter int DW    = 16,
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [DLY_W-1:0] ack_dly,
  input logic             cap_addr,
  input logic             cap_data,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic             ack,
  input logic [DW-1:0]    dout
);

  localparam int CW = DLY_W + 2;
  localparam logic [CW-1:0] MUTE_LIM = CW'((1 << DLY_W) + 2);

  logic             any_stb;
  logic [CW-1:0]    mute_run;

  assign any_stb = cap_addr | cap_data | wr_stb | rd_stb;

  always_ff @(posedge clk) begin
    if (rst)                    mute_run <= '0;
    else if (ack_dly != '1)     mute_run <= '0;
    else if (mute_run != MUTE_LIM) mute_run <= mute_run + 1'b1;
  end

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ack && !any_stb) |=> !ack); // R6

  AST_ACK_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(!ack, 2)); // R6

  AST_DOUT_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    !$rose(ack) |-> $stable(dout)); // R5

  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mute_run == MUTE_LIM && !ack) |=> !ack); // R7

endmodule

bind hsk_reg_target hsk_reg_target_chk #(
  .DW    (DW),
  .DLY_W (DLY_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ack_dly  (ack_dly),
  .cap_addr (cap_addr),
  .cap_data (cap_data),
  .wr_stb   (wr_stb),
  .rd_stb   (rd_stb),
  .ack      (ack),
  .dout     (dout)
);

// File: tb/hsk_reg_target_tb.sv
module hsk_reg_target_tb;

  localparam int          DW    = 16;
  localparam int          DEPTH = 16;
  localparam int          DLY_W = 4;
  localparam logic [15:0] BASE  = 16'hA5C3;
  localparam logic [15:0] STEP  = 16'h0111;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DLY_W-1:0] ack_dly = '0;
  logic [DW-1:0]    din = '0;
  logic [3:0]       stb = '0;  // 0 addr, 1 data, 2 write, 3 read
  logic             ack;
  logic [DW-1:0]    dout;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [DEPTH];

  always #5 clk = ~clk;

  hsk_reg_target #(
    .DW(DW), .DEPTH(DEPTH), .DLY_W(DLY_W), .RST_BASE(BASE), .RST_STEP(STEP)
  ) u_dut (
    .clk(clk), .rst(rst), .ack_dly(ack_dly), .din(din),
    .cap_addr(stb[0]), .cap_data(stb[1]), .wr_stb(stb[2]), .rd_stb(stb[3]),
    .ack(ack), .dout(dout)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // full four-phase transfer on the lanes in mask; checks latency and release
  task automatic xfer(input logic [3:0] mask, input logic [15:0] val);
    int lat;
    lat = 0;
    din = val;
    stb = mask;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 40);
    chk("R6 ack latency", 32'(lat), 32'(ack_dly) + 2);
    stb = '0;
    @(negedge clk);
    chk("R6 ack falls after release", 32'(ack), 0);
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] exp);
    xfer(4'b1000, 16'h0);
    chk(tag, 32'(dout), 32'(exp));
  endtask

  initial begin : watchdog
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < DEPTH; i++) model[i] = BASE + 16'(i) * STEP;
    repeat (3) @(negedge clk);
    chk("R1 ack reset", 32'(ack), 0);
    chk("R1 dout reset", 32'(dout), 0);
    rst = 1'b0;
    repeat (DEPTH + 4) @(negedge clk);

    // R1 reset pattern, swept over four delays
    for (int i = 0; i < DEPTH; i++) begin
      ack_dly = 4'(i % 4);
      xfer(4'b0001, 16'(i));
      rd_chk("R1 reset pattern", model[i]);
    end

    // R2 R3 R4 sweep with junk upper address bits
    for (int i = 0; i < DEPTH; i++) begin
      logic [15:0] v;
      v = (16'(i) * 16'h1357) ^ 16'h2468;
      ack_dly = 4'((i * 3) % 7);
      xfer(4'b0001, (16'(i * 7 + 1) << 4) | 16'(i));
      xfer(4'b0010, v);
      rd_chk("R3 capture data leaves register", model[i]);
      xfer(4'b0100, 16'h0);
      rd_chk("R4 write commits", v);
      model[i] = v;
    end

    // R2 aliasing read back
    ack_dly = 4'd1;
    for (int i = 0; i < DEPTH; i++) begin
      xfer(4'b0001, 16'h8000 | 16'(i << 8) | 16'(i));
      rd_chk("R2 upper address bits ignored", model[i]);
    end

    // R5 dout held across non-read ops
    ack_dly = 4'd0;
    xfer(4'b0001, 16'd3);
    rd_chk("R5 read", model[3]);
    xfer(4'b0001, 16'd9);
    xfer(4'b0010, 16'h7777);
    chk("R5 dout held", 32'(dout), 32'(model[3]));

    // R7 suppressed acknowledge, write attempted at addr 9 with pending 7777
    ack_dly = '1;
    stb = 4'b0100;
    repeat (40) @(negedge clk);
    chk("R7 no ack while muted", 32'(ack), 0);
    stb = '0;
    repeat (2) @(negedge clk);
    ack_dly = 4'd0;
    chk("R7 dout untouched", 32'(dout), 32'(model[3]));
    rd_chk("R7 register untouched", model[9]);

    // R8 write raised while ack high is ignored
    din = 16'd9;
    stb = 4'b0001;
    do @(negedge clk); while (!ack);
    stb = 4'b0101;
    @(negedge clk);
    stb = 4'b0100;
    repeat (20) @(negedge clk);
    chk("R8 late strobe not acked", 32'(ack), 0);
    stb = '0;
    @(negedge clk);
    rd_chk("R8 late write ignored", model[9]);

    // R9 cap_addr beats write: addr becomes 5, no write at 9
    xfer(4'b0101, 16'd5);
    rd_chk("R9 addr wins over write", model[5]);
    xfer(4'b0001, 16'd9);
    rd_chk("R9 old address not written", model[9]);
    // cap_data beats write
    xfer(4'b0110, 16'h4321);
    rd_chk("R9 data wins over write", model[9]);
    xfer(4'b0100, 16'h0);
    model[9] = 16'h4321;
    rd_chk("R9 captured data commits later", model[9]);
    // write beats read: dout must not change
    xfer(4'b0001, 16'd2);
    xfer(4'b0010, 16'hBEEF);
    xfer(4'b1100, 16'h0);
    chk("R9 read lost to write", 32'(dout), 32'(model[9]));
    model[2] = 16'hBEEF;
    rd_chk("R9 write served", model[2]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule